// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block connects a 32-bit internal master to an external 32-bit big-endian data bus. The device on that bus may be 8, 16 or 32 bits wide, and a 2-bit port-size input says which. The master presents one request: an address, a size (byte, halfword or word), a direction and write data. The controller runs as many external beats as the device width needs. It puts each byte on the lane that matches its address, drives active-high byte enables, and collects read bytes into a right-justified result.

Every external beat stays on the bus until the device acknowledges it. The request completes with a one-cycle done pulse after the final acknowledge. A misaligned halfword or word request produces a one-cycle error pulse and no bus activity. The port size and the request fields are sampled when the request is accepted. A request is accepted only while the block is idle.

Top module: `bus_sizer`

## Requirements
- R1: Port-size decoding is 2'b00 for a 32-bit device, 2'b01 for an 8-bit device, and 2'b10 or 2'b11 for a 16-bit device.
- R2: Request size 2'b00 is 1 byte, 2'b01 is 2 bytes, and 2'b10 or 2'b11 is 4 bytes. An aligned request of N bytes on a W-byte port takes N/W beats when N > W, and one beat otherwise.
- R3: The request bytes are numbered 0..N-1, byte 0 being the most significant byte of the right-justified data and lying at the request address. The byte at address b travels on data bits [31-8*(b mod W) -: 8]. For example, on a 16-bit port an odd-address byte uses D23..D16.
- R4: Beat k drives the address request_address + k*min(N,W), with its low log2(W) bits driven as zero.
- R5: BE[3] marks D31..D24 and BE[0] marks D7..D0. A write asserts only the lanes it carries, and lanes outside the port carry zero. A read asserts every lane of the port: 4'b1000 for 8 bits, 4'b1100 for 16 bits, 4'b1111 for 32 bits.
- R6: A beat keeps ext_cyc, address, enables and write data steady until ext_ack is sampled high. The next beat starts in the following cycle.
- R7: done pulses for exactly one cycle, in the cycle after the last beat's acknowledge. rdata then holds the read result, right-justified with zero upper bits, until the next request is accepted.
- R8: A halfword at an odd address, or a word whose address bits 1:0 are not zero, gives a one-cycle err pulse in the next cycle, with no beat and no done.
- R9: A request presented while busy is high is dropped and has no effect on the bus or the device.
- R10: During and after reset, busy, done, err and ext_cyc are low, and ext_be is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-justified write data |
| port_size | input | 2 | Width of the attached device |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle misalignment pulse |
| rdata | output | 32 | Right-justified read result |
| ext_cyc | output | 1 | External beat active |
| ext_we | output | 1 | External beat is a write |
| ext_addr | output | AW | External address |
| ext_be | output | 4 | Active-high byte-lane enables |
| ext_wdata | output | 32 | External write data lanes |
| ext_rdata | input | 32 | External read data lanes |
| ext_ack | input | 1 | Beat acknowledge from the device |

## Verification
A wrong beat counter or a stale plan register shows at once as an extra or missing acknowledged beat. It also shows as an external address that does not step by the port width, and the device model flags it on the very beat where it happens. A wrong lane index lands a byte at the wrong device address. Writes followed by reads through a different port width show that at the next readback. The same fault puts a wrong byte in rdata in the cycle that done pulses. Misaligned and dropped requests are judged from err, done, the beat count, and a later readback of the location they could have written.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES = 4;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_BEAT = 1'b1} st_e;

  typedef struct packed {
    logic [2:0] nbytes;   // request bytes
    logic [2:0] wbytes;   // port bytes
    logic [2:0] bbytes;   // bytes per beat
    logic [2:0] beats;    // beat count
    logic       misalign;
  } plan_t;

  function automatic logic [2:0] port_bytes(input logic [1:0] ps);
    case (ps)
      2'b00:   return 3'd4;
      2'b01:   return 3'd1;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bsz_plan.sv
module bsz_plan
  import bsz_pkg::*;
(
  input  logic [1:0] port_size,
  input  logic [1:0] req_size,
  input  logic [1:0] addr_lo,
  output plan_t      plan
);
  logic [2:0] n, w;

  always_comb begin
    n = size_bytes(req_size);
    w = port_bytes(port_size);
    plan.nbytes   = n;
    plan.wbytes   = w;
    plan.bbytes   = (n < w) ? n : w;
    if (n == 3'd4 && w == 3'd1)
      plan.beats = 3'd4;
    else if (n > w)
      plan.beats = 3'd2;
    else
      plan.beats = 3'd1;
    plan.misalign = ((n == 3'd2) && addr_lo[0]) ||
                    ((n == 3'd4) && (addr_lo != 2'b00));
  end
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
  import bsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  plan_t             plan,
  input  logic [AW-1:0]     base,
  input  logic [1:0]        beat,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              active,
  output logic [AW-1:0]     addr,
  output logic [3:0]        be,
  output logic [31:0]       wlanes,
  output logic [3:0]        sel_valid,
  output logic [3:0][1:0]   sel_lane
);
  logic [3:0]    first;
  logic [1:0]    mask;
  logic [AW-1:0] beat_addr;
  logic [31:0]   wjust;
  logic [5:0]    shift;

  always_comb begin
    first     = {2'b00, beat} * {1'b0, plan.bbytes};
    mask      = plan.wbytes[1:0] - 2'd1;
    beat_addr = base + AW'(first);
    shift     = {(3'd4 - plan.nbytes), 3'b000};
    wjust     = wdata << shift;
    be        = 4'b0000;
    wlanes    = 32'h0;
    sel_valid = 4'b0000;
    sel_lane  = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [3:0] idx;
      logic [1:0] lane;
      logic       inb;
      idx  = 4'(i);
      lane = (base[1:0] + 2'(i)) & mask;
      inb  = (idx < {1'b0, plan.nbytes}) && (idx >= first) &&
             (idx < first + {1'b0, plan.bbytes});
      sel_valid[i] = inb;
      sel_lane[i]  = lane;
      if (inb && we && active) begin
        be[3 - int'(lane)] = 1'b1;
        wlanes[8*(3 - int'(lane)) +: 8] = wjust[8*(3 - i) +: 8];
      end
    end
    if (!we && active) begin
      case (plan.wbytes)
        3'd1:    be = 4'b1000;
        3'd2:    be = 4'b1100;
        default: be = 4'b1111;
      endcase
    end
    addr = active ? (beat_addr & ~{{(AW-2){1'b0}}, mask}) : '0;
  end
endmodule

// File: rtl/bsz_gather.sv
module bsz_gather
  import bsz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             capture,
  input  logic [3:0]       sel_valid,
  input  logic [3:0][1:0]  sel_lane,
  input  logic [2:0]       nbytes,
  input  logic [31:0]      ext_rdata,
  output logic [31:0]      rdata
);
  logic [7:0] byte_q [LANES];
  logic [7:0] byte_d [LANES];
  logic [5:0] shift;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      byte_d[i] = byte_q[i];
      if (clear)
        byte_d[i] = 8'h00;
      else if (capture && sel_valid[i])
        byte_d[i] = ext_rdata[8*(3 - int'(sel_lane[i])) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) byte_q[i] <= 8'h00;
    end else if (clear || capture) begin
      for (int i = 0; i < LANES; i++) byte_q[i] <= byte_d[i];
    end
  end

  always_comb begin
    shift = {(3'd4 - nbytes), 3'b000};
    rdata = {byte_q[0], byte_q[1], byte_q[2], byte_q[3]} >> shift;
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic [1:0]    port_size,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata,
  output logic          ext_cyc,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [3:0]    ext_be,
  output logic [31:0]   ext_wdata,
  input  logic [31:0]   ext_rdata,
  input  logic          ext_ack
);
  st_e           st_q, st_d;
  logic [1:0]    k_q, k_d;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [31:0]   wdata_q;
  plan_t         plan_q, plan_in;
  logic          done_q, done_d, err_q, err_d;
  logic          accept, load, beat_ack, last;
  logic [3:0]    sel_valid;
  logic [3:0][1:0] sel_lane;

  bsz_plan u_plan (
    .port_size (port_size),
    .req_size  (req_size),
    .addr_lo   (req_addr[1:0]),
    .plan      (plan_in)
  );

  bsz_lanes #(.AW(AW)) u_lanes (
    .plan      (plan_q),
    .base      (addr_q),
    .beat      (k_q),
    .wdata     (wdata_q),
    .we        (we_q),
    .active    (ext_cyc),
    .addr      (ext_addr),
    .be        (ext_be),
    .wlanes    (ext_wdata),
    .sel_valid (sel_valid),
    .sel_lane  (sel_lane)
  );

  bsz_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (load),
    .capture   (beat_ack && !we_q),
    .sel_valid (sel_valid),
    .sel_lane  (sel_lane),
    .nbytes    (plan_q.nbytes),
    .ext_rdata (ext_rdata),
    .rdata     (rdata)
  );

  always_comb begin
    accept   = (st_q == ST_IDLE) && req_valid;
    load     = accept && !plan_in.misalign;
    beat_ack = (st_q == ST_BEAT) && ext_ack;
    last     = ({1'b0, k_q} + 3'd1) == plan_q.beats;
    st_d     = st_q;
    k_d      = k_q;
    done_d   = 1'b0;
    err_d    = accept && plan_in.misalign;
    if (load) begin
      st_d = ST_BEAT;
      k_d  = 2'd0;
    end else if (beat_ack) begin
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        k_d = k_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= 2'd0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= 32'h0;
      plan_q  <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      we_q    <= req_write;
      wdata_q <= req_wdata;
      plan_q  <= plan_in;
    end
  end

  always_comb begin
    busy    = (st_q != ST_IDLE);
    ext_cyc = (st_q == ST_BEAT);
    ext_we  = ext_cyc && we_q;
    done    = done_q;
    err     = err_q;
  end
endmodule

// File: rtl/bsz_checks.sv
module bsz_checks #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    port_size,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          ext_cyc,
  input logic          ext_we,
  input logic [AW-1:0] ext_addr,
  input logic [3:0]    ext_be,
  input logic [31:0]   ext_wdata,
  input logic          ext_ack
);
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && !ext_ack |=> ext_cyc && $stable(ext_addr) && $stable(ext_be) && $stable(ext_wdata)); // R6
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ext_ack && ext_cyc)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ext_cyc && !done && !busy); // R8
  AST_PORT8_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && port_size == 2'b01 |-> ext_be[2:0] == 3'b000 && ext_wdata[23:0] == 24'h0); // R5
  AST_PORT16_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && port_size[1] |-> ext_be[1:0] == 2'b00 && ext_wdata[15:0] == 16'h0 && !ext_addr[0]); // R4
  AST_PORT32_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc && port_size == 2'b00 |-> ext_addr[1:0] == 2'b00); // R4
  AST_BEAT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cyc |-> ext_be != 4'b0000); // R5
  AST_WE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> ext_cyc); // R10
endmodule

bind bus_sizer bsz_checks #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_size (port_size),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .ext_cyc   (ext_cyc),
  .ext_we    (ext_we),
  .ext_addr  (ext_addr),
  .ext_be    (ext_be),
  .ext_wdata (ext_wdata),
  .ext_ack   (ext_ack)
);

// File: tb/bus_sizer_tb.sv
`timescale 1ns/1ps
module bus_sizer_tb;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0] req_size, port_size;
  logic [31:0] req_wdata, rdata, ext_wdata, ext_rdata;
  logic busy, done, err, ext_cyc, ext_we, ext_ack;
  logic [AW-1:0] ext_addr;
  logic [3:0] ext_be;

  always #2.5 clk = ~clk;

  bus_sizer #(.AW(AW)) u_dut (.*);

  int total = 0, bad = 0;
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  int beats_seen;
  int cur_w, cur_n, cur_bb;
  logic [5:0] cur_addr;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Device model: acknowledges every beat at the negedge after it appears
  always @(negedge clk) begin
    if (ext_ack) ext_ack = 1'b0;
    else if (ext_cyc) begin
      logic [31:0] ea;
      ea = 32'((cur_addr + 6'(beats_seen * cur_bb)) & ~6'(cur_w - 1));
      chk(32'(ext_addr) == ea, "R4 beat address", 32'(ext_addr), ea);
      if (ext_we) begin
        for (int j = cur_w; j < 4; j++)
          chk(ext_wdata[8*(3-j) +: 8] == 8'h00 && !ext_be[3-j], "R5 unused lane", ext_wdata, 32'h0);
      end else begin
        chk(ext_be == (cur_w == 1 ? 4'b1000 : cur_w == 2 ? 4'b1100 : 4'b1111), "R5 read enables",
            32'(ext_be), 32'(cur_w == 1 ? 4'b1000 : cur_w == 2 ? 4'b1100 : 4'b1111));
      end
      ext_rdata = 32'hDBDBDBDB;
      for (int j = 0; j < cur_w; j++) begin
        if (ext_we) begin
          if (ext_be[3-j]) mem[ext_addr[5:0] + 6'(j)] = ext_wdata[8*(3-j) +: 8];
        end else
          ext_rdata[8*(3-j) +: 8] = mem[ext_addr[5:0] + 6'(j)];
      end
      beats_seen++;
      ext_ack = 1'b1;
    end
  end

  task automatic run_op(input logic [1:0] ps, input logic [1:0] sz, input logic we,
                        input logic [5:0] ad, input logic [31:0] wd, input int exp_beats,
                        input bit mis, input bit poke, input string tag);
    int dn = 0, er = 0;
    logic [31:0] exp = 0;
    logic [31:0] held;
    @(negedge clk);
    port_size = ps;
    cur_w  = (ps == 2'b00) ? 4 : (ps == 2'b01) ? 1 : 2;
    cur_n  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    cur_bb = (cur_n < cur_w) ? cur_n : cur_w;
    cur_addr = ad;
    beats_seen = 0;
    req_valid = 1'b1; req_size = sz; req_write = we; req_addr = AW'(ad); req_wdata = wd;
    @(negedge clk);
    if (done) dn++;
    if (err) er++;
    req_valid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (dn + er > 0 && !busy) break;
      if (poke && c == 1) begin
        req_valid = 1'b1; req_size = 2'b00; req_write = 1'b1; req_addr = AW'(6'd20); req_wdata = 32'hFF;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (done) dn++;
      if (err) er++;
    end
    if (mis) begin
      chk(er == 1 && dn == 0, {"R8 err pulse ", tag}, 32'(er), 32'd1);
      chk(beats_seen == 0, {"R8 no beat ", tag}, 32'(beats_seen), 32'd0);
    end else begin
      chk(dn == 1 && er == 0, {"R7 done pulse ", tag}, 32'(dn), 32'd1);
      chk(beats_seen == exp_beats, {"R2 beats ", tag}, 32'(beats_seen), 32'(exp_beats));
      if (we) begin
        for (int i = 0; i < cur_n; i++) shadow[ad + 6'(i)] = wd[8*(cur_n-1-i) +: 8];
      end else begin
        for (int i = 0; i < cur_n; i++) exp = (exp << 8) | 32'(shadow[ad + 6'(i)]);
        chk(rdata == exp, {"R3 read data ", tag}, rdata, exp);
        held = rdata;
        @(negedge clk); @(negedge clk);
        chk(rdata == held, {"R7 rdata hold ", tag}, rdata, held);
      end
    end
  endtask

  typedef struct packed {
    logic [1:0]  ps;
    logic [1:0]  sz;
    logic        we;
    logic [5:0]  ad;
    logic [31:0] wd;
    logic [2:0]  nb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 2'b10, 1'b1, 6'd0,  32'h11223344, 3'd4},
    '{2'b01, 2'b10, 1'b0, 6'd0,  32'h0,        3'd4},
    '{2'b10, 2'b01, 1'b0, 6'd2,  32'h0,        3'd1},
    '{2'b10, 2'b00, 1'b0, 6'd1,  32'h0,        3'd1},
    '{2'b10, 2'b00, 1'b0, 6'd0,  32'h0,        3'd1},
    '{2'b10, 2'b00, 1'b1, 6'd3,  32'h000000A5, 3'd1},
    '{2'b00, 2'b10, 1'b0, 6'd0,  32'h0,        3'd1},
    '{2'b10, 2'b10, 1'b1, 6'd4,  32'h55667788, 3'd2},
    '{2'b11, 2'b10, 1'b0, 6'd4,  32'h0,        3'd2},
    '{2'b00, 2'b01, 1'b1, 6'd6,  32'h0000BEEF, 3'd1},
    '{2'b01, 2'b01, 1'b0, 6'd6,  32'h0,        3'd2},
    '{2'b00, 2'b00, 1'b1, 6'd5,  32'h0000009C, 3'd1},
    '{2'b01, 2'b00, 1'b0, 6'd5,  32'h0,        3'd1},
    '{2'b00, 2'b00, 1'b0, 6'd7,  32'h0,        3'd1},
    '{2'b00, 2'b01, 1'b0, 6'd4,  32'h0,        3'd1},
    '{2'b00, 2'b11, 1'b0, 6'd4,  32'h0,        3'd1}
  };

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) begin
      mem[a] = 8'(a * 13 + 5);
      shadow[a] = mem[a];
    end
    ext_ack = 1'b0; ext_rdata = 32'h0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'b00; req_wdata = 32'h0;
    port_size = 2'b00; beats_seen = 0; cur_w = 4; cur_n = 1; cur_bb = 1; cur_addr = 6'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs during reset
    chk(!busy && !done && !err && !ext_cyc && ext_be == 4'h0, "R10 reset state",
        {busy, done, err, ext_cyc, ext_be}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ext_cyc, "R10 after release", {busy, ext_cyc}, 32'h0);

    // R1 R2 R3 R4 R5: table of vectors
    for (int v = 0; v < NV; v++)
      run_op(VEC[v].ps, VEC[v].sz, VEC[v].we, VEC[v].ad, VEC[v].wd, int'(VEC[v].nb), 1'b0, 1'b0, $sformatf("vec%0d", v));

    // R8: misaligned halfword and word
    run_op(2'b10, 2'b01, 1'b1, 6'd9,  32'h1234, 0, 1'b1, 1'b0, "half odd");
    run_op(2'b00, 2'b10, 1'b0, 6'd10, 32'h0,    0, 1'b1, 1'b0, "word off2");
    run_op(2'b01, 2'b11, 1'b1, 6'd13, 32'h1,    0, 1'b1, 1'b0, "word off1");
    // R8: the misaligned writes left the device untouched
    run_op(2'b00, 2'b10, 1'b0, 6'd8,  32'h0,    1, 1'b0, 1'b0, "R8 readback 8");
    run_op(2'b00, 2'b10, 1'b0, 6'd12, 32'h0,    1, 1'b0, 1'b0, "R8 readback 12");

    // R9: request offered while busy is dropped; location 20 must keep its value
    run_op(2'b01, 2'b10, 1'b1, 6'd16, 32'hCAFEF00D, 4, 1'b0, 1'b1, "R9 busy poke");
    run_op(2'b00, 2'b10, 1'b0, 6'd20, 32'h0,        1, 1'b0, 1'b0, "R9 readback");
    run_op(2'b10, 2'b10, 1'b0, 6'd16, 32'h0,        2, 1'b0, 1'b0, "R6 word on 16");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule